// File: doc/BRIEF.md
# Fail-First Vector Subtract Sequencer

This block walks a vector held in an external register file and, for each element, subtracts a scalar operand, writes the difference back to the same element slot and builds a 4-bit condition field from the sign of the difference. Each condition field is checked against a programmable test. The first element whose test fires ends the loop early, and the vector length is cut back to reflect how far the loop got. A mode bit decides whether the element that fires the test is still written and counted, or is dropped before writeback.

A single `start` pulse launches a run. The block reads one element per clock through a combinational read port, presents the write and condition-field strobes in that same cycle, and raises `done` for one cycle once the final length has been committed. The maximum length and the step counters are reported back so that the caller can restore its loop state. A second mode omits the condition fields and tests for a zero difference only.

Top module: `failfirst_seq`

## Requirements
- R1: For element i the block reads index i and writes `elemData - scalarOp` (two's complement, DW bits) to `wrIdx = i` with `wrEn` high, unless R4 suppresses that write.
- R2: With `condEnable` = 1, each processed element produces a condition field with bit 3 = difference negative, bit 2 = difference positive, bit 1 = difference zero, bit 0 = 0, presented on `condField` with `condWrEn` high and `condIdx = i`. The element that fires the test also gets its field.
- R3: With `condEnable` = 1, an element fires the test when bit `condSel` of its condition field XOR `condInvert` is 1 (so `condSel`=1, `condInvert`=0 stops on zero; `condSel`=2, `condInvert`=1 stops on zero or negative).
- R4: With `vliMode` = 0, the firing element is not written and the new length equals its index.
- R5: With `vliMode` = 1, the firing element is written and the new length equals its index plus one.
- R6: With `condEnable` = 0, `condSel` and `condInvert` are ignored, the test fires on a zero difference, and no condition field is written.
- R7: The loop bound is the smallest of `vlIn`, `maxVlIn` and MAX_ELEMS; if no element fires, `vlOut` equals that bound, and no index at or beyond the bound is ever written.
- R8: One element is processed per clock: element i is presented in the (i+1)-th cycle after the edge that samples `start`; after n processed elements, `done` is high for exactly one cycle, the cycle after the n-th edge following that start edge.
- R9: A loop bound of 0 raises `done` in the cycle right after the start edge, with `vlOut` = 0 and no writes.
- R10: While `done` is high, `srcStep` and `dstStep` are 0 and `maxVlOut` equals the `maxVlIn` sampled at start.
- R11: A `start` pulse while a run is in progress is ignored and does not alter that run's writes or its final length.
- R12: After reset `done`, `wrEn` and `condWrEn` are 0 and `vlOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, sampled when idle |
| vlIn | input | LW | Requested vector length |
| maxVlIn | input | LW | Maximum vector length |
| condSel | input | 2 | Condition field bit used by the test |
| condInvert | input | 1 | Inverts the selected bit before testing |
| vliMode | input | 1 | 1: firing element is written and counted |
| condEnable | input | 1 | 1: write condition fields and use the selectable test |
| scalarOp | input | DW | Scalar subtrahend |
| elemIdx | output | IW | Read index into the register file |
| elemData | input | DW | Element read at `elemIdx` |
| wrEn | output | 1 | Element write strobe |
| wrIdx | output | IW | Element write index |
| wrData | output | DW | Element write data |
| condWrEn | output | 1 | Condition field write strobe |
| condIdx | output | IW | Condition field index |
| condField | output | 4 | Condition field value |
| vlOut | output | LW | Committed vector length |
| maxVlOut | output | LW | Maximum length, returned unchanged |
| srcStep | output | IW | Source step counter |
| dstStep | output | IW | Destination step counter |
| done | output | 1 | One-cycle completion pulse |

## Verification
Element and condition-field strobes are combinational on the step counter, so element i is due in the (i+1)-th cycle after the start edge and `done` in the cycle after the n-th edge, n being the number of processed elements. The driver computes n and the ordered list of expected writes and fields from the requirements, pushing them into queues; a monitor pops one item for every strobe it sees at the falling edge, so a missing, extra or misplaced write is caught. The driver counts falling edges from the start edge and checks that `done` is low one cycle before it is due, high exactly when due, and low again one cycle later, and it reads the length, maximum length and step counters in the `done` cycle.

// File: rtl/ffseq_pkg.sv
`timescale 1ns/1ps
package ffseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seqState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic       active;
    logic       vliMode;
    logic       condEnable;
    logic [1:0] condSel;
    logic       condInvert;
  } ctrlStrobes_t;

  localparam int unsigned FIELD_W = 4;
  localparam int unsigned BIT_NEG = 3;
  localparam int unsigned BIT_POS = 2;
  localparam int unsigned BIT_ZERO = 1;

endpackage

// File: rtl/ffseq_datapath.sv
`timescale 1ns/1ps
module ffseq_datapath
  import ffseq_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned IW = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strobes,
  input  logic [IW-1:0]          stepIdx,
  input  logic [DW-1:0]          elemData,
  input  logic [DW-1:0]          scalarOp,
  output logic                   wrEn,
  output logic [IW-1:0]          wrIdx,
  output logic [DW-1:0]          wrData,
  output logic                   condWrEn,
  output logic [IW-1:0]          condIdx,
  output logic [FIELD_W-1:0]     condField,
  output logic                   elemFail
);

  logic [DW-1:0]      diff;
  logic               isNeg;
  logic               isZero;
  logic               isPos;
  logic [FIELD_W-1:0] field;
  logic               selBit;
  logic               testHit;

  always_comb begin
    diff   = elemData - scalarOp;
    isNeg  = diff[DW-1];
    isZero = (diff == '0);
    isPos  = !isNeg && !isZero;
    field  = '0;
    field[BIT_NEG]  = isNeg;
    field[BIT_POS]  = isPos;
    field[BIT_ZERO] = isZero;
    selBit = field[strobes.condSel];
    // without condition fields only the zero test is applied
    testHit = strobes.condEnable ? (selBit ^ strobes.condInvert) : isZero;
  end

  assign elemFail  = strobes.active && testHit;
  assign wrEn      = strobes.active && (!testHit || strobes.vliMode);
  assign wrIdx     = stepIdx;
  assign wrData    = diff;
  assign condWrEn  = strobes.active && strobes.condEnable;
  assign condIdx   = stepIdx;
  assign condField = field;

  // exactly one sign flag is set and the low bit stays clear
  assert_field_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    condWrEn |-> ($countones(condField) == 1 && condField[0] == 1'b0));

  // no strobe leaks out while idle
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.active |-> (!wrEn && !condWrEn));

endmodule

// File: rtl/ffseq_ctrl.sv
`timescale 1ns/1ps
module ffseq_ctrl
  import ffseq_pkg::*;
#(
  parameter int unsigned MAX_ELEMS = 16,
  parameter int unsigned IW = 4,
  parameter int unsigned LW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [LW-1:0] vlIn,
  input  logic [LW-1:0] maxVlIn,
  input  logic [1:0]    condSel,
  input  logic          condInvert,
  input  logic          vliMode,
  input  logic          condEnable,
  input  logic          elemFail,
  output ctrlStrobes_t  strobes,
  output logic [IW-1:0] stepIdx,
  output logic [LW-1:0] vlOut,
  output logic [LW-1:0] maxVlOut,
  output logic [IW-1:0] srcStep,
  output logic [IW-1:0] dstStep,
  output logic          done
);

  localparam logic [LW-1:0] CAP = LW'(MAX_ELEMS);

  seqState_t     state;
  logic [LW-1:0] lenReg;
  logic [LW-1:0] reqLen;
  logic [LW-1:0] effLen;
  logic [LW-1:0] nextPos;
  logic          lastElem;
  logic          cfgVli;
  logic          cfgCondEn;
  logic [1:0]    cfgSel;
  logic          cfgInv;

  always_comb begin
    reqLen   = (vlIn < maxVlIn) ? vlIn : maxVlIn;
    effLen   = (reqLen > CAP) ? CAP : reqLen;
    nextPos  = LW'(srcStep) + LW'(1);
    lastElem = (nextPos == lenReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      lenReg    <= '0;
      vlOut     <= '0;
      maxVlOut  <= '0;
      srcStep   <= '0;
      dstStep   <= '0;
      cfgVli    <= 1'b0;
      cfgCondEn <= 1'b0;
      cfgSel    <= '0;
      cfgInv    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            lenReg    <= effLen;
            maxVlOut  <= maxVlIn;
            srcStep   <= '0;
            dstStep   <= '0;
            cfgVli    <= vliMode;
            cfgCondEn <= condEnable;
            cfgSel    <= condSel;
            cfgInv    <= condInvert;
            if (effLen == '0) begin
              vlOut <= '0;
              state <= ST_DONE;
            end else begin
              state <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (elemFail || lastElem) begin
            if (elemFail) begin
              vlOut <= cfgVli ? nextPos : LW'(srcStep);
            end else begin
              vlOut <= lenReg;
            end
            srcStep <= '0;
            dstStep <= '0;
            state   <= ST_DONE;
          end else begin
            srcStep <= srcStep + IW'(1);
            dstStep <= dstStep + IW'(1);
          end
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    strobes.active     = (state == ST_RUN);
    strobes.vliMode    = cfgVli;
    strobes.condEnable = cfgCondEn;
    strobes.condSel    = cfgSel;
    strobes.condInvert = cfgInv;
  end

  assign stepIdx = srcStep;
  assign done    = (state == ST_DONE);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_step_in_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.active |-> (LW'(srcStep) < lenReg));

  assert_steps_cleared_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (srcStep == '0 && dstStep == '0));

  assert_vl_bounded_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (vlOut <= lenReg));

  assert_restart_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.active && start) |=> $stable(lenReg));

endmodule

// File: rtl/failfirst_seq.sv
`timescale 1ns/1ps
module failfirst_seq
  import ffseq_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned MAX_ELEMS = 16,
  localparam int unsigned IW = (MAX_ELEMS > 1) ? $clog2(MAX_ELEMS) : 1,
  localparam int unsigned LW = $clog2(MAX_ELEMS + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [LW-1:0] vlIn,
  input  logic [LW-1:0] maxVlIn,
  input  logic [1:0]    condSel,
  input  logic          condInvert,
  input  logic          vliMode,
  input  logic          condEnable,
  input  logic [DW-1:0] scalarOp,
  output logic [IW-1:0] elemIdx,
  input  logic [DW-1:0] elemData,
  output logic          wrEn,
  output logic [IW-1:0] wrIdx,
  output logic [DW-1:0] wrData,
  output logic          condWrEn,
  output logic [IW-1:0] condIdx,
  output logic [3:0]    condField,
  output logic [LW-1:0] vlOut,
  output logic [LW-1:0] maxVlOut,
  output logic [IW-1:0] srcStep,
  output logic [IW-1:0] dstStep,
  output logic          done
);

  ctrlStrobes_t  strobes;
  logic [IW-1:0] stepIdx;
  logic          elemFail;

  ffseq_ctrl #(.MAX_ELEMS(MAX_ELEMS), .IW(IW), .LW(LW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .vlIn(vlIn), .maxVlIn(maxVlIn),
    .condSel(condSel), .condInvert(condInvert), .vliMode(vliMode),
    .condEnable(condEnable), .elemFail(elemFail), .strobes(strobes),
    .stepIdx(stepIdx), .vlOut(vlOut), .maxVlOut(maxVlOut),
    .srcStep(srcStep), .dstStep(dstStep), .done(done)
  );

  ffseq_datapath #(.DW(DW), .IW(IW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .stepIdx(stepIdx),
    .elemData(elemData), .scalarOp(scalarOp), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrData(wrData), .condWrEn(condWrEn), .condIdx(condIdx),
    .condField(condField), .elemFail(elemFail)
  );

  assign elemIdx = stepIdx;

endmodule

// File: tb/failfirst_seq_tb.sv
`timescale 1ns/1ps
module failfirst_seq_tb;

  localparam int DW = 16;
  localparam int IW = 4;
  localparam int LW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [LW-1:0] vlIn = '0;
  logic [LW-1:0] maxVlIn = '0;
  logic [1:0]    condSel = '0;
  logic          condInvert = 1'b0;
  logic          vliMode = 1'b0;
  logic          condEnable = 1'b0;
  logic [DW-1:0] scalarOp = '0;
  logic [IW-1:0] elemIdx;
  logic [DW-1:0] elemData;
  logic          wrEn;
  logic [IW-1:0] wrIdx;
  logic [DW-1:0] wrData;
  logic          condWrEn;
  logic [IW-1:0] condIdx;
  logic [3:0]    condField;
  logic [LW-1:0] vlOut;
  logic [LW-1:0] maxVlOut;
  logic [IW-1:0] srcStep;
  logic [IW-1:0] dstStep;
  logic          done;

  logic [DW-1:0] mem [16];
  assign elemData = mem[elemIdx];

  int total = 0;
  int bad = 0;
  logic [IW+DW-1:0] wrQ[$];
  logic [IW+3:0]    cfQ[$];

  always #2.5 clk = ~clk;

  failfirst_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .vlIn(vlIn), .maxVlIn(maxVlIn),
    .condSel(condSel), .condInvert(condInvert), .vliMode(vliMode),
    .condEnable(condEnable), .scalarOp(scalarOp), .elemIdx(elemIdx),
    .elemData(elemData), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .condWrEn(condWrEn), .condIdx(condIdx), .condField(condField),
    .vlOut(vlOut), .maxVlOut(maxVlOut), .srcStep(srcStep),
    .dstStep(dstStep), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per observed strobe
  always @(negedge clk) begin
    if (rstN && wrEn) begin
      if (wrQ.size() == 0) check(1'b0, "R7 unexpected write idx", wrIdx, -1);
      else begin
        logic [IW+DW-1:0] e;
        e = wrQ.pop_front();
        check({wrIdx, wrData} == e, "R1 write idx/data", {wrIdx, wrData}, e);
      end
    end
    if (rstN && condWrEn) begin
      if (cfQ.size() == 0) check(1'b0, "R6 unexpected cond field idx", condIdx, -1);
      else begin
        logic [IW+3:0] c;
        c = cfQ.pop_front();
        check({condIdx, condField} == c, "R2 cond idx/field", {condIdx, condField}, c);
      end
    end
  end

  function automatic logic [3:0] fieldOf(input logic [DW-1:0] r);
    if (r[DW-1]) return 4'b1000;
    if (r == '0) return 4'b0010;
    return 4'b0100;
  endfunction

  task automatic runCase(input string tag, input int vl, input int mvl, input int sc,
                         input int sel, input bit inv, input bit vli, input bit cen,
                         input bit poke);
    int bound;
    int n;
    int expVl;
    bound = (vl < mvl) ? vl : mvl;
    if (bound > 16) bound = 16;
    n = bound;
    expVl = bound;
    for (int i = 0; i < bound; i++) begin
      logic [DW-1:0] r;
      logic [3:0] f;
      bit hit;
      r = mem[i] - DW'(sc);
      f = fieldOf(r);
      hit = cen ? (f[sel] ^ inv) : (r == '0);
      if (cen) cfQ.push_back({IW'(i), f});
      if (!hit || vli) wrQ.push_back({IW'(i), r});
      if (hit) begin
        n = i + 1;
        expVl = vli ? i + 1 : i;
        break;
      end
    end
    @(negedge clk);
    vlIn = LW'(vl); maxVlIn = LW'(mvl); scalarOp = DW'(sc);
    condSel = 2'(sel); condInvert = inv; vliMode = vli; condEnable = cen;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cnt = 1; cnt <= n; cnt++) begin
      if (cnt == n) check(done == 1'b0, {tag, " R8 done early"}, done, 0);
      @(negedge clk);
      start = poke && (cnt == 1);
      if (poke && cnt == 1) begin
        vlIn = 1; maxVlIn = 1; vliMode = ~vli;
      end
    end
    start = 1'b0;
    check(done == 1'b1, {tag, " R8 done due"}, done, 1);
    check(vlOut == LW'(expVl), {tag, " R4/R5/R7 new length"}, vlOut, expVl);
    check(maxVlOut == LW'(mvl), {tag, " R10 maxvl kept"}, maxVlOut, mvl);
    check(srcStep == 0 && dstStep == 0, {tag, " R10 steps cleared"}, {srcStep, dstStep}, 0);
    check(wrQ.size() == 0, {tag, " R1 missing writes"}, wrQ.size(), 0);
    check(cfQ.size() == 0, {tag, " R2 missing cond fields"}, cfQ.size(), 0);
    @(negedge clk);
    check(done == 1'b0, {tag, " R8 done single cycle"}, done, 0);
    wrQ.delete();
    cfQ.delete();
  endtask

  task automatic loadVec(input int a, input int b, input int c, input int d);
    for (int i = 0; i < 16; i++) mem[i] = DW'(100 + i);
    mem[0] = DW'(a); mem[1] = DW'(b); mem[2] = DW'(c); mem[3] = DW'(d);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    loadVec(9, 8, 3, 4);
    repeat (3) @(negedge clk);
    check(done == 1'b0 && wrEn == 1'b0 && condWrEn == 1'b0, "R12 reset strobes", {done, wrEn, condWrEn}, 0);
    check(vlOut == '0, "R12 reset length", vlOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R3 R4: stop on zero, failing element dropped -> length 2
    runCase("eq-vli0", 4, 4, 3, 1, 1'b0, 1'b0, 1'b1, 1'b0);
    // R5: failing element kept -> length 3
    runCase("eq-vli1", 4, 4, 3, 1, 1'b0, 1'b1, 1'b1, 1'b0);
    // R6: no cond fields, zero test, selector ignored
    runCase("nocr", 4, 4, 3, 3, 1'b1, 1'b0, 1'b0, 1'b0);
    // R3: less-or-equal stop
    loadVec(9, 8, 2, 4);
    runCase("le", 4, 4, 3, 2, 1'b1, 1'b0, 1'b1, 1'b0);
    // R7: no failure keeps the length
    loadVec(5, 6, 7, 8);
    runCase("nofail", 4, 8, 1, 1, 1'b0, 1'b0, 1'b1, 1'b0);
    // R7: bound clamped by maxVlIn, nothing beyond written
    runCase("clamp", 6, 3, 1, 1, 1'b0, 1'b1, 1'b1, 1'b0);
    // R9: empty vector
    runCase("empty", 0, 4, 1, 1, 1'b0, 1'b0, 1'b1, 1'b0);
    // R3: negative at first element, vli 0 -> length 0
    loadVec(2, 1, 0, 7);
    runCase("neg0", 4, 4, 5, 3, 1'b0, 1'b0, 1'b1, 1'b0);
    // R11: restart attempt during a run is ignored
    loadVec(5, 6, 7, 8);
    runCase("poke", 4, 4, 1, 1, 1'b0, 1'b0, 1'b1, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule